// File: doc/BRIEF.md
# Demand-Paged Address Translator with Hardware Table Walk

This block sits between a processor and memory and turns 32-bit logical addresses into physical ones. A direct-mapped translation cache answers most accesses in the same cycle: on a hit the physical address and physical strobe are driven straight away, and no memory traffic is generated. On a miss the translator holds the processor off the bus and walks a three-level descriptor tree in main memory through its own read port. At each level it checks the index limit and the access rights. It then writes the page translation into the cache and asks the processor to retry. The retried access hits.

Software first loads the base address and limit of the top-level table through a root write port. A flush input clears every cache entry in one cycle, for use when the address space changes. A free-running counter reports how many cycles the processor has been held off by walks.

Top module: `page_walk_mmu`

## Requirements
- R1: The logical address splits into a 7-bit top index (bits 31..25), a 7-bit middle index (bits 24..18), an 8-bit bottom index (bits 17..10) and a 10-bit offset (bits 9..0). The offset appears unchanged in physical address bits 9..0. Physical bits 31..10 are the frame number of the page.
- R2: A root write loads the top-table base and a 7-bit top limit. Until the first root write, any request is answered with an error and no memory read.
- R3: On a cache hit with sufficient rights, `phys_strobe` and `phys_addr` are driven in the same cycle as the request, and no memory read is issued.
- R4: On a miss, `cpu_hold` is high for every cycle of the walk. A successful walk ends with a one-cycle `cpu_retry`, and the repeated access then hits.
- R5: A walk reads two 32-bit words at top_base + 8*top_index (offset +0, then +4), then two words at middle_base + 8*middle_index, then one word at bottom_base + 4*bottom_index. Pointer word 0 holds the next level's limit in bits 7..0 and rights in bits 10..8. Pointer word 1 holds the next table's base. The page word holds the frame in bits 31..10, a valid flag in bit 3 and rights in bits 2..0.
- R6: If an index exceeds the limit for its level, the walk ends with a one-cycle `cpu_err` and no further reads. The top limit is checked before any read, the middle limit after one read, and the bottom limit after three reads.
- R7: Rights bit 0 permits user reads, bit 1 user writes, and bit 2 supervisor writes. Supervisor reads are always allowed, and function-code bit 2 set means supervisor. A denial at any level ends the walk with an error. On a hit, the cached rights (the AND of all three levels) are checked, and a denial gives an immediate error without a walk.
- R8: A cache entry is selected by {FC2, FC1, logical bits 16..10} and matched on logical bits 31..17. FC0 takes no part. Two addresses with the same index and different tags evict each other.
- R9: `wait_cycles` increases by one for every cycle in which `cpu_hold` is high and holds its value otherwise.
- R10: A `flush_all` pulse invalidates every cache entry, so the next access to any page walks again.
- R11: A page word with its valid flag clear ends the walk with an error and fills no cache entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_we | input | 1 | Load root base and limit |
| root_base_in | input | 32 | Top-level table base address |
| root_limit_in | input | 7 | Highest legal top index |
| flush_all | input | 1 | Invalidate every cache entry |
| cpu_req | input | 1 | Logical address strobe |
| cpu_addr | input | 32 | Logical address |
| cpu_fc | input | 3 | Function code; bit 2 marks supervisor |
| cpu_wr | input | 1 | 1 = write access |
| cpu_hold | output | 1 | Processor held off during a walk |
| cpu_retry | output | 1 | Walk finished; repeat the access |
| cpu_err | output | 1 | Access refused |
| phys_strobe | output | 1 | Physical address strobe |
| phys_addr | output | 32 | Physical address |
| mem_rd | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Descriptor word |
| wait_cycles | output | CNT_W | Count of held cycles |

## Verification
The hardest situation to reach is a cache conflict. An entry already filled with one tag must be displaced by a second address that shares its index, and the first address must then walk again. The stimulus table therefore uses the same bottom index under different top and middle indices, so that consecutive fills land in one entry. It then returns to the first address. Errors raised at the top, middle and bottom levels are told apart by the held-cycle count, which the bench predicts from the number of descriptor reads at a fixed memory latency.

// File: rtl/page_walk_mmu.sv
module page_walk_mmu #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             root_we,
  input  logic [31:0]      root_base_in,
  input  logic [6:0]       root_limit_in,
  input  logic             flush_all,
  input  logic             cpu_req,
  input  logic [31:0]      cpu_addr,
  input  logic [2:0]       cpu_fc,
  input  logic             cpu_wr,
  output logic             cpu_hold,
  output logic             cpu_retry,
  output logic             cpu_err,
  output logic             phys_strobe,
  output logic [31:0]      phys_addr,
  output logic             mem_rd,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [CNT_W-1:0] wait_cycles
);
  localparam int IDX_W   = 9;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = 15;
  localparam int FRM_W   = 22;

  typedef enum logic [2:0] {S_IDLE, S_T1A, S_T1B, S_T2A, S_T2B, S_PG, S_RESP} st_t;

  function automatic logic rights_ok(input logic [2:0] p, input logic sup, input logic wr);
    rights_ok = sup ? (!wr || p[2]) : (wr ? p[1] : p[0]);
  endfunction

  st_t         st;
  logic [31:0] root_base, base_q, la_q, ent;
  logic [6:0]  root_lim;
  logic        root_ok, wr_q, err_q;
  logic [2:0]  fc_q, prot_q;

  logic [TAG_W-1:0] tag_mem [ENTRIES];
  logic [FRM_W-1:0] frm_mem [ENTRIES];
  logic [2:0]       prm_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  wire [IDX_W-1:0] cidx = {cpu_fc[2:1], cpu_addr[16:10]};
  wire [IDX_W-1:0] fidx = {fc_q[2:1], la_q[16:10]};
  wire hit     = vld[cidx] && (tag_mem[cidx] == cpu_addr[31:17]);
  wire look_ok = rights_ok(prm_mem[cidx], cpu_fc[2], cpu_wr);
  wire idle    = (st == S_IDLE);
  wire pg_ok   = mem_rdata[3] && rights_ok(mem_rdata[2:0], fc_q[2], wr_q);
  wire fill    = (st == S_PG) && mem_ack && pg_ok;

  wire [6:0] i1 = la_q[31:25];
  wire [6:0] i2 = la_q[24:18];
  wire [7:0] i3 = la_q[17:10];

  assign phys_strobe = idle && cpu_req && root_ok && hit && look_ok;
  assign phys_addr   = {frm_mem[cidx], cpu_addr[9:0]};
  assign cpu_hold    = !idle && (st != S_RESP);
  assign mem_rd      = cpu_hold;
  assign cpu_retry   = (st == S_RESP) && !err_q;
  assign cpu_err     = ((st == S_RESP) && err_q) ||
                       (idle && cpu_req && (!root_ok || (hit && !look_ok)));

  always_comb begin
    case (st)
      S_T1A, S_T1B: ent = root_base + {22'd0, i1, 3'd0};
      S_T2A, S_T2B: ent = base_q + {22'd0, i2, 3'd0};
      default:      ent = base_q + {22'd0, i3, 2'd0};
    endcase
  end
  assign mem_addr = ent + ((st == S_T1B || st == S_T2B) ? 32'd4 : 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      root_base <= '0; root_lim <= '0; root_ok <= 1'b0;
      base_q <= '0; la_q <= '0; fc_q <= '0; wr_q <= 1'b0;
      prot_q <= '0; err_q <= 1'b0;
      vld <= '0;
      wait_cycles <= '0;
    end else begin
      if (root_we) begin
        root_base <= root_base_in;
        root_lim  <= root_limit_in;
        root_ok   <= 1'b1;
      end
      if (cpu_hold) wait_cycles <= wait_cycles + 1'b1;
      if (flush_all)  vld <= '0;
      else if (fill)  vld[fidx] <= 1'b1;
      case (st)
        S_IDLE: if (cpu_req && root_ok && !hit) begin
          la_q <= cpu_addr; fc_q <= cpu_fc; wr_q <= cpu_wr; prot_q <= 3'b111;
          if (cpu_addr[31:25] > root_lim) begin err_q <= 1'b1; st <= S_RESP; end
          else begin err_q <= 1'b0; st <= S_T1A; end
        end
        S_T1A: if (mem_ack) begin
          prot_q <= prot_q & mem_rdata[10:8];
          if (!rights_ok(mem_rdata[10:8], fc_q[2], wr_q) || {1'b0, i2} > mem_rdata[7:0]) begin
            err_q <= 1'b1; st <= S_RESP;
          end else st <= S_T1B;
        end
        S_T1B: if (mem_ack) begin base_q <= mem_rdata; st <= S_T2A; end
        S_T2A: if (mem_ack) begin
          prot_q <= prot_q & mem_rdata[10:8];
          if (!rights_ok(mem_rdata[10:8], fc_q[2], wr_q) || i3 > mem_rdata[7:0]) begin
            err_q <= 1'b1; st <= S_RESP;
          end else st <= S_T2B;
        end
        S_T2B: if (mem_ack) begin base_q <= mem_rdata; st <= S_PG; end
        S_PG: if (mem_ack) begin err_q <= !pg_ok; st <= S_RESP; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_mem[fidx] <= la_q[31:17];
      frm_mem[fidx] <= mem_rdata[31:10];
      prm_mem[fidx] <= prot_q & mem_rdata[2:0];
    end
  end

  assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_strobe |-> !mem_rd);
  assert_retry_after_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> $past(st) == S_PG);
  assert_no_walk_unrooted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !root_ok |-> !mem_rd);
  assert_top_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cpu_req && root_ok && !hit && cpu_addr[31:25] > root_lim) |=> (cpu_err && !mem_rd));
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !phys_strobe);
  assert_count_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |=> wait_cycles == CNT_W'($past(wait_cycles) + 1'b1));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |=> $stable(wait_cycles));
endmodule

// File: tb/tb_page_walk_mmu.sv
module tb_page_walk_mmu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic root_we = 1'b0, flush_all = 1'b0, cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [31:0] root_base_in = '0, cpu_addr = '0;
  logic [6:0]  root_limit_in = '0;
  logic [2:0]  cpu_fc = '0;
  logic cpu_hold, cpu_retry, cpu_err, phys_strobe, mem_rd;
  logic [31:0] phys_addr, mem_addr;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] wait_cycles;

  always #10 clk = ~clk;

  page_walk_mmu dut (.*);

  logic [31:0] mem [1024];
  logic [31:0] rlog [16];
  int rlog_n = 0, lat = 2, mcnt = 0;
  int nchk = 0, nfail = 0;

  always @(negedge clk) begin
    if (mem_rd && mcnt == lat) begin
      mem_ack = 1'b1; mem_rdata = mem[mem_addr[11:2]]; mcnt = 0;
      if (rlog_n < 16) rlog[rlog_n] = mem_addr;
      rlog_n++;
    end else begin
      mem_ack = 1'b0;
      if (mem_rd) mcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] la, input logic [2:0] fc, input logic wr,
                        output int kind, output logic [31:0] pa, output int dw);
    int w0;
    @(negedge clk);
    cpu_addr = la; cpu_fc = fc; cpu_wr = wr; cpu_req = 1'b1;
    w0 = int'(wait_cycles); kind = 3; pa = '0;
    for (int n = 0; n < 400; n++) begin
      #1;
      if (phys_strobe) begin kind = 0; pa = phys_addr; end
      else if (cpu_retry) kind = 1;
      else if (cpu_err) kind = 2;
      if (kind != 3) break;
      @(negedge clk);
    end
    cpu_req = 1'b0;
    dw = int'(wait_cycles) - w0;
  endtask

  typedef struct packed {
    logic [2:0]  fc;
    logic        wr;
    logic [31:0] la;
    logic [1:0]  kind;   // 0 hit, 1 retry, 2 error
    logic [2:0]  nrd;    // descriptor reads the walk performs
    logic [31:0] pa;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [23] = '{
    '{3'd1,1'b0,{7'd0,7'd0,8'd0,10'h3A5},2'd1,3'd5,32'h0,4'd4},          // R4 first touch
    '{3'd1,1'b0,{7'd0,7'd0,8'd0,10'h3A5},2'd0,3'd0,32'h048D17A5,4'd3},   // R3 hit
    '{3'd1,1'b1,{7'd0,7'd0,8'd0,10'h004},2'd0,3'd0,32'h048D1404,4'd7},   // R7 user write allowed
    '{3'd5,1'b0,{7'd0,7'd0,8'd0,10'h010},2'd1,3'd5,32'h0,4'd8},          // R8 FC2 selects new entry
    '{3'd5,1'b0,{7'd0,7'd0,8'd0,10'h010},2'd0,3'd0,32'h048D1410,4'd8},
    '{3'd0,1'b0,{7'd0,7'd0,8'd0,10'h020},2'd0,3'd0,32'h048D1420,4'd8},   // R8 FC0 ignored
    '{3'd1,1'b0,{7'd0,7'd0,8'd1,10'h000},2'd1,3'd5,32'h0,4'd5},          // R5
    '{3'd1,1'b0,{7'd0,7'd0,8'd1,10'h000},2'd0,3'd0,32'h002AF000,4'd1},   // R1
    '{3'd1,1'b1,{7'd0,7'd0,8'd1,10'h008},2'd2,3'd0,32'h0,4'd7},          // R7 cached deny
    '{3'd5,1'b1,{7'd0,7'd0,8'd1,10'h000},2'd2,3'd5,32'h0,4'd7},          // R7 page-level deny
    '{3'd1,1'b0,{7'd0,7'd0,8'd2,10'h000},2'd2,3'd5,32'h0,4'd11},         // R11 invalid page
    '{3'd1,1'b0,{7'd0,7'd0,8'd2,10'h000},2'd2,3'd5,32'h0,4'd11},         // R11 not cached
    '{3'd1,1'b0,{7'd0,7'd0,8'h11,10'h000},2'd2,3'd3,32'h0,4'd6},         // R6 bottom limit
    '{3'd1,1'b0,{7'd4,7'd0,8'd0,10'h000},2'd2,3'd0,32'h0,4'd6},          // R6 top limit
    '{3'd1,1'b0,{7'd0,7'd3,8'd0,10'h000},2'd2,3'd1,32'h0,4'd6},          // R6 middle limit
    '{3'd1,1'b1,{7'd1,7'd0,8'd0,10'h000},2'd2,3'd1,32'h0,4'd7},          // R7 top-level deny
    '{3'd1,1'b0,{7'd1,7'd0,8'd0,10'h055},2'd1,3'd5,32'h0,4'd4},
    '{3'd1,1'b0,{7'd1,7'd0,8'd0,10'h055},2'd0,3'd0,32'h00026455,4'd1},
    '{3'd5,1'b1,{7'd1,7'd0,8'd0,10'h000},2'd1,3'd5,32'h0,4'd7},          // R7 supervisor write
    '{3'd1,1'b0,{7'd0,7'd1,8'd0,10'h000},2'd1,3'd5,32'h0,4'd8},          // R8 conflict
    '{3'd1,1'b0,{7'd0,7'd1,8'd0,10'h000},2'd0,3'd0,32'h00015400,4'd8},
    '{3'd1,1'b0,{7'd0,7'd0,8'd0,10'h3A5},2'd1,3'd5,32'h0,4'd8},          // R8 evicted
    '{3'd1,1'b0,{7'd0,7'd0,8'd0,10'h3A5},2'd0,3'd0,32'h048D17A5,4'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int k, dw;
    logic [31:0] pa;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[0] = 32'h702;   mem[1] = 32'h100;
    mem[2] = 32'h505;   mem[3] = 32'h200;
    mem[64] = 32'h710;  mem[65] = 32'h300;
    mem[66] = 32'h703;  mem[67] = 32'h380;
    mem[128] = 32'h708; mem[129] = 32'h400;
    mem[192] = 32'h048D140F; mem[193] = 32'h002AF009; mem[194] = 32'h0;
    mem[224] = 32'h0001540F; mem[256] = 32'h0002640F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R3 reset strobe", phys_strobe, 0);
    chk("R4 reset hold", cpu_hold, 0);
    chk("R4 reset mem_rd", mem_rd, 0);
    chk("R9 reset count", wait_cycles, 0);

    access({7'd0,7'd0,8'd0,10'h3A5}, 3'd1, 1'b0, k, pa, dw);
    chk("R2 unrooted kind", k, 2);
    chk("R2 unrooted reads", rlog_n, 0);
    chk("R2 unrooted hold", dw, 0);

    @(negedge clk);
    root_we = 1'b1; root_base_in = 32'h0; root_limit_in = 7'd3;
    @(negedge clk);
    root_we = 1'b0;

    for (int i = 0; i < 23; i++) begin
      access(VEC[i].la, VEC[i].fc, VEC[i].wr, k, pa, dw);
      chk($sformatf("R%0d vec%0d kind", VEC[i].rq, i), k, VEC[i].kind);
      chk($sformatf("R9 vec%0d held cycles", i), dw, VEC[i].nrd * (lat + 1));
      if (VEC[i].kind == 2'd0) chk($sformatf("R%0d vec%0d paddr", VEC[i].rq, i), pa, VEC[i].pa);
    end

    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    access({7'd0,7'd0,8'd0,10'h3A5}, 3'd1, 1'b0, k, pa, dw);
    chk("R10 walk after flush", k, 1);

    lat = 0; rlog_n = 0;
    access({7'd0,7'd0,8'd1,10'h000}, 3'd1, 1'b0, k, pa, dw);
    chk("R4 retry", k, 1);
    chk("R9 zero-latency walk", dw, 5);
    chk("R5 read count", rlog_n, 5);
    chk("R5 addr0", rlog[0], 32'h000);
    chk("R5 addr1", rlog[1], 32'h004);
    chk("R5 addr2", rlog[2], 32'h100);
    chk("R5 addr3", rlog[3], 32'h104);
    chk("R5 addr4", rlog[4], 32'h304);
    access({7'd0,7'd0,8'd1,10'h2C3}, 3'd1, 1'b0, k, pa, dw);
    chk("R1 offset passthrough", pa, 32'h002AF2C3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule